// File: doc/BRIEF.md
# Two-Address Serial Slave for a Sixteen-Port Expander

This block is the two-wire bus slave of a sixteen-port expander. It answers two 7-bit bus addresses. Both share the same low address bits, which come from a separate pin decoder. The first address reaches group A, a byte of mixed ports. Four of those ports are open-drain I/Os watched by a transition-detect block. The second address reaches group B, a byte of push-pull outputs. The block finds START and STOP conditions, shifts address and data bits in and out, drives the acknowledge, and runs the read and write sequences of each group.

A write updates the output latch of the addressed group once for every data byte. A read of group A alternates two kinds of byte. One is a port byte, freshly sampled by the neighbouring transition-detect block through a one-cycle strobe. The other is the transition-flag byte that block held before the same strobe cleared it. A read of group B returns the real pin levels of its outputs, resampled for every byte. The bus lines arrive as clean samples already synchronised to `clk`. `sda_oe_o` pulls the data line low when it is high.

Top module: `pxp_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte only if its upper seven bits equal {3'b110, addr_lo_i} (group A) or {3'b101, addr_lo_i} (group B). Bit 0 is the direction: 1 means read. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R2: A byte takes nine SCL clocks, most significant bit first. On the ninth clock the receiver drives the acknowledge (SDA low) for the whole of that clock's high phase.
- R3: A port byte read from group A is `snap_a_i` as it stands after the sample strobe. Bit 7 down to bit 0 carry O7, O6, P5, P4, P3, P2, O1, O0.
- R4: A group A read returns a port byte first and a flag byte second, and keeps alternating until the master stops. Each flag byte is the `flags_a_i` value seen in the cycle the preceding sample strobe was issued, before that strobe clears it.
- R5: `sample_a_o` and `flag_clr_a_o` pulse for one clock during SCL high. They pulse on the address acknowledge of every group A access, and on each master acknowledge that precedes a group A port byte. Group B accesses never pulse them.
- R6: Each byte of a group B read is `pins_b_i` as sampled during the acknowledge clock just before that byte.
- R7: A write updates the whole output latch of the addressed group with each received data byte, at that byte's acknowledge. The latch of the other group does not change.
- R8: After a master not-acknowledge, the slave leaves SDA released on every further clock until a STOP or a START. A repeated START decodes a fresh address.
- R9: While `bus_rst_n` is low, the slave releases SDA by the next clock and returns to idle. The output latches keep their values.
- R10: After `rst_n`, SDA is released, `out_a_o` equals parameter RST_A and `out_b_o` equals parameter RST_B.
- R11: The slave starts pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst_n | input | 1 | Active-low bus abort |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| addr_lo_i | input | 4 | Low address bits from the pin decoder |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| snap_a_i | input | 8 | Group A snapshot from the transition-detect block |
| flags_a_i | input | 8 | Group A transition flags |
| sample_a_o | output | 1 | Strobe: take a new group A snapshot |
| flag_clr_a_o | output | 1 | Strobe: clear the group A flags |
| pins_b_i | input | 8 | Actual group B pin levels |
| out_a_o | output | 8 | Group A output latch |
| out_b_o | output | 8 | Group B output latch |

## Verification
The assertions assume that SCL stays at each level for several clocks. The strobes are then seen while SCL is still high, and the latches change while SCL is low. They also assume that the master changes SDA only while SCL is low, except when it forms a START or STOP. The bench master holds each SCL phase for six clocks and moves SDA only in the clock where SCL falls. A reference model of the output latches is updated at the moment each data byte is completed. It is compared with the outputs on every clock.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_HOLD
   } pxp_st_e;

   typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} pxp_grp_e;
endpackage

// File: rtl/pxp_bus_cond.sv
module pxp_bus_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
      end
   end

   assign scl_rise_o = scl_i & ~scl_q;
   assign scl_fall_o = ~scl_i & scl_q;
   assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
   assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/pxp_addr_match.sv
module pxp_addr_match #(
   parameter int unsigned LO_W  = 4,
   parameter int unsigned PFX_W = 3,
   parameter logic [PFX_W-1:0] PFX_A = 3'b110,
   parameter logic [PFX_W-1:0] PFX_B = 3'b101
) (
   input  logic [7:0]      byte_i,
   input  logic [LO_W-1:0] lo_i,
   output logic            hit_a_o,
   output logic            hit_b_o,
   output logic            rd_o
);
   localparam int unsigned ADDR_W = PFX_W + LO_W;

   if (ADDR_W != 7) begin : g_bad_width
      $error("address prefix plus low bits must total seven");
   end
   if (PFX_A == PFX_B) begin : g_bad_prefix
      $error("the two group prefixes must differ");
   end

   assign hit_a_o = (byte_i[7:1] == {PFX_A, lo_i});
   assign hit_b_o = (byte_i[7:1] == {PFX_B, lo_i});
   assign rd_o    = byte_i[0];
endmodule

// File: rtl/pxp_port_reg.sv
module pxp_port_reg #(
   parameter int unsigned W = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   for (genvar g = 0; g < W; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q_o[g] <= RST[g];
         else if (we_i) q_o[g] <= d_i[g];
      end
   end
endmodule

// File: rtl/pxp_i2c_slave.sv
module pxp_i2c_slave
   import pxp_pkg::*;
#(
   parameter int unsigned GRP_W = 8,
   parameter int unsigned LO_W  = 4,
   parameter int unsigned PFX_W = 3,
   parameter logic [PFX_W-1:0] PFX_A = 3'b110,
   parameter logic [PFX_W-1:0] PFX_B = 3'b101,
   parameter logic [GRP_W-1:0] RST_A = 8'hC3,
   parameter logic [GRP_W-1:0] RST_B = 8'h0F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   input  logic [LO_W-1:0]  addr_lo_i,
   output logic             sda_oe_o,
   input  logic [GRP_W-1:0] snap_a_i,
   input  logic [GRP_W-1:0] flags_a_i,
   output logic             sample_a_o,
   output logic             flag_clr_a_o,
   input  logic [GRP_W-1:0] pins_b_i,
   output logic [GRP_W-1:0] out_a_o,
   output logic [GRP_W-1:0] out_b_o
);
   localparam int unsigned CNT_W = $clog2(GRP_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(GRP_W);

   if (GRP_W != 8) begin : g_bad_grp
      $error("each port group must be one bus byte wide");
   end

   logic scl_rise, scl_fall, start, stop;
   logic hit_a, hit_b, rd_bit;
   pxp_st_e st;
   pxp_grp_e grp;
   logic [CNT_W-1:0] bitcnt;
   logic [7:0] sh, tx, nb, flag_hold, pin_hold;
   logic rd, flag_next, sample_q, wr_fire;

   pxp_bus_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start), .stop_o(stop)
   );

   pxp_addr_match #(.LO_W(LO_W), .PFX_W(PFX_W), .PFX_A(PFX_A), .PFX_B(PFX_B)) u_match (
      .byte_i(sh), .lo_i(addr_lo_i),
      .hit_a_o(hit_a), .hit_b_o(hit_b), .rd_o(rd_bit)
   );

   // byte loaded for the next read transfer
   always_comb begin
      if (grp == GRP_B)   nb = pin_hold;
      else if (flag_next) nb = flag_hold;
      else                nb = snap_a_i;
   end

   assign wr_fire = bus_rst_n & ~start & ~stop & (st == ST_WR) & scl_fall & (bitcnt == FULL);

   pxp_port_reg #(.W(GRP_W), .RST(RST_A)) u_reg_a (
      .clk(clk), .rst_n(rst_n), .we_i(wr_fire & (grp == GRP_A)), .d_i(sh), .q_o(out_a_o)
   );
   pxp_port_reg #(.W(GRP_W), .RST(RST_B)) u_reg_b (
      .clk(clk), .rst_n(rst_n), .we_i(wr_fire & (grp == GRP_B)), .d_i(sh), .q_o(out_b_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         grp       <= GRP_A;
         bitcnt    <= '0;
         sh        <= '0;
         tx        <= '0;
         flag_hold <= '0;
         pin_hold  <= '0;
         rd        <= 1'b0;
         flag_next <= 1'b0;
         sample_q  <= 1'b0;
         sda_oe_o  <= 1'b0;
      end else begin
         sample_q <= 1'b0;
         if (!bus_rst_n || stop) begin
            st       <= ST_IDLE;
            sda_oe_o <= 1'b0;
         end else if (start) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_oe_o <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh     <= {sh[6:0], sda_i};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     if (hit_a || hit_b) begin
                        sda_oe_o  <= 1'b1;
                        st        <= ST_AACK;
                        grp       <= hit_a ? GRP_A : GRP_B;
                        rd        <= rd_bit;
                        flag_next <= 1'b0;
                     end else begin
                        st <= ST_HOLD;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_rise) begin
                     if (grp == GRP_A) begin
                        sample_q  <= 1'b1;
                        flag_hold <= flags_a_i;
                     end
                     pin_hold <= pins_b_i;
                  end else if (scl_fall) begin
                     bitcnt <= '0;
                     if (rd) begin
                        tx        <= nb;
                        sda_oe_o  <= ~nb[7];
                        flag_next <= ~flag_next;
                        st        <= ST_RD;
                     end else begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_WR;
                     end
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall) begin
                     if (bitcnt == FULL) begin
                        sda_oe_o <= 1'b0;
                        st       <= ST_RACK;
                     end else begin
                        sda_oe_o <= ~tx[6];
                        tx       <= {tx[6:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     if (sda_i) begin
                        st <= ST_HOLD;
                     end else begin
                        if (grp == GRP_A && !flag_next) begin
                           sample_q  <= 1'b1;
                           flag_hold <= flags_a_i;
                        end
                        pin_hold <= pins_b_i;
                     end
                  end else if (scl_fall) begin
                     bitcnt    <= '0;
                     tx        <= nb;
                     sda_oe_o  <= ~nb[7];
                     flag_next <= ~flag_next;
                     st        <= ST_RD;
                  end
               end
               ST_WR: begin
                  if (scl_rise) begin
                     sh     <= {sh[6:0], sda_i};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL) begin
                     sda_oe_o <= 1'b1;
                     st       <= ST_WACK;
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe_o <= 1'b0;
                     bitcnt   <= '0;
                     st       <= ST_WR;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sample_a_o   = sample_q;
   assign flag_clr_a_o = sample_q;

   // R11
   sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_i);

   // R9
   abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rst_n |=> !sda_oe_o);

   // R5
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_a_o |=> !sample_a_o);

   // R5
   strobe_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_a_o |-> scl_i);

   // R7
   latch_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_a_o) |-> (!scl_i && sda_oe_o));

   // R7
   latch_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(out_b_o) |-> (!scl_i && sda_oe_o));
endmodule

// File: tb/pxp_i2c_slave_bench.sv
module pxp_i2c_slave_bench;
   localparam int H = 6;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0, bus_rst_n = 1'b1, m_scl = 1'b1, m_sda = 1'b1;
   logic [3:0] lo = 4'b0101;
   logic [7:0] pins_a = 8'h00, pins_b = 8'h00, snap = 8'h00, flags = 8'h00, flag_inj = 8'h00;
   logic sda_oe, samp, fclr;
   logic [7:0] out_a, out_b;
   logic sda_bus;
   assign sda_bus = m_sda & ~sda_oe;

   pxp_i2c_slave u_pxp_i2c_slave (
      .clk(clk), .rst_n(rst_n), .bus_rst_n(bus_rst_n),
      .scl_i(m_scl), .sda_i(sda_bus), .addr_lo_i(lo), .sda_oe_o(sda_oe),
      .snap_a_i(snap), .flags_a_i(flags), .sample_a_o(samp), .flag_clr_a_o(fclr),
      .pins_b_i(pins_b), .out_a_o(out_a), .out_b_o(out_b)
   );

   int n_chk = 0, n_fail = 0, n_samp = 0;
   logic [7:0] exp_a = 8'hC3, exp_b = 8'h0F;
   logic mon_on = 1'b0;

   // neighbouring transition-detect block
   always @(posedge clk) begin
      if (fclr) flags <= 8'h00;
      else      flags <= flags | flag_inj;
      if (samp) begin
         snap   <= pins_a;
         n_samp <= n_samp + 1;
      end
   end

   // latch reference model compared on every clock (R7, R9, R10)
   always @(posedge clk) begin
      #3;
      if (mon_on) begin
         n_chk++;
         if (out_a !== exp_a || out_b !== exp_b) begin
            n_fail++;
            $display("FAIL R7 latches: actual %h/%h expected %h/%h", out_a, out_b, exp_a, exp_b);
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic m_start();
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b0; tick(H);
      m_scl = 1'b0; tick(1);
   endtask

   task automatic m_stop();
      m_sda = 1'b0; tick(H);
      m_scl = 1'b1; tick(H);
      m_sda = 1'b1; tick(H);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; tick(H);
      m_scl = 1'b1; tick(H);
      m_scl = 1'b0;
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; tick(H);
      m_scl = 1'b1; tick(H / 2);
      b = sda_bus; tick(H - H / 2);
      m_scl = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v, input logic upd_a, input logic upd_b, output logic ack);
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      if (upd_a) exp_a = v;
      if (upd_b) exp_b = v;
      get_bit(ack);
   endtask

   task automatic get_byte(input logic mack, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~mack);
   endtask

   initial begin
      logic ack;
      logic [7:0] v;
      int n0;
      tick(3); rst_n = 1'b1; tick(2); mon_on = 1'b1;

      // R10 reset state
      chk("R10 out_a", out_a, 8'hC3);
      chk("R10 out_b", out_b, 8'h0F);
      chk("R10 sda", {7'b0, sda_oe}, 8'h00);
      chk("R5 idle strobes", n_samp[7:0], 8'h00);

      // group A write, two bytes (R1 R2 R7 R5)
      m_start();
      put_byte(8'hCA, 1'b0, 1'b0, ack); chk("R1 ack A write", {7'b0, ack}, 8'h00);
      put_byte(8'h3C, 1'b1, 1'b0, ack); chk("R2 data ack", {7'b0, ack}, 8'h00);
      put_byte(8'h81, 1'b1, 1'b0, ack); chk("R2 data ack 2", {7'b0, ack}, 8'h00);
      m_stop();
      chk("R7 out_a", out_a, 8'h81);
      chk("R5 one strobe on A write", n_samp[7:0], 8'h01);

      // group A long read (R3 R4 R5)
      pins_a = 8'h5A;
      flag_inj = 8'h05; tick(1); flag_inj = 8'h00;
      n0 = n_samp;
      m_start();
      put_byte(8'hCB, 1'b0, 1'b0, ack); chk("R1 ack A read", {7'b0, ack}, 8'h00);
      get_byte(1'b1, v); chk("R3 port byte", v, 8'h5A);
      pins_a = 8'hA5;
      flag_inj = 8'h10; tick(1); flag_inj = 8'h00;
      get_byte(1'b1, v); chk("R4 flag byte", v, 8'h05);
      get_byte(1'b1, v); chk("R3 resampled port", v, 8'hA5);
      get_byte(1'b0, v); chk("R4 second flag byte", v, 8'h10);
      m_stop();
      chk("R5 strobes in A read", 8'(n_samp - n0), 8'h02);
      chk("R5 flags cleared", flags, 8'h00);

      // group B read, NACK, repeated START (R6 R8)
      n0 = n_samp;
      pins_b = 8'h3E;
      m_start();
      put_byte(8'hAB, 1'b0, 1'b0, ack); chk("R1 ack B read", {7'b0, ack}, 8'h00);
      pins_b = 8'hC1;
      get_byte(1'b1, v); chk("R6 first pin byte", v, 8'h3E);
      get_byte(1'b0, v); chk("R6 resampled pins", v, 8'hC1);
      get_byte(1'b0, v); chk("R8 released after NACK", v, 8'hFF);
      chk("R5 no strobe for B", 8'(n_samp - n0), 8'h00);
      m_start();
      put_byte(8'hCA, 1'b0, 1'b0, ack); chk("R8 repeated START ack", {7'b0, ack}, 8'h00);
      put_byte(8'h99, 1'b1, 1'b0, ack);
      m_stop();
      chk("R7 out_a after restart", out_a, 8'h99);

      // group B write (R7)
      m_start();
      put_byte(8'hAA, 1'b0, 1'b0, ack); chk("R1 ack B write", {7'b0, ack}, 8'h00);
      put_byte(8'h77, 1'b0, 1'b1, ack);
      m_stop();
      chk("R7 out_b", out_b, 8'h77);
      chk("R7 out_a kept", out_a, 8'h99);

      // foreign addresses (R1)
      m_start();
      put_byte(8'hEA, 1'b0, 1'b0, ack); chk("R1 bad prefix", {7'b0, ack}, 8'h01);
      put_byte(8'h00, 1'b0, 1'b0, ack); chk("R1 ignored data", {7'b0, ack}, 8'h01);
      m_stop();
      m_start();
      put_byte(8'hC8, 1'b0, 1'b0, ack); chk("R1 bad low bits", {7'b0, ack}, 8'h01);
      m_stop();

      // bus abort during address acknowledge (R9)
      m_start();
      for (int i = 7; i >= 0; i--) put_bit(v[i] ^ v[i] ^ (8'hAA >> i) & 1'b1);
      tick(2);
      chk("R2 ack driven", {7'b0, sda_oe}, 8'h01);
      bus_rst_n = 1'b0; tick(1);
      chk("R9 released", {7'b0, sda_oe}, 8'h00);
      bus_rst_n = 1'b1;
      get_bit(ack); chk("R9 no ack after abort", {7'b0, ack}, 8'h01);
      put_byte(8'h12, 1'b0, 1'b0, ack); chk("R9 idle after abort", {7'b0, ack}, 8'h01);
      m_stop();
      chk("R9 out_b kept", out_b, 8'h77);

      tick(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule